// File: doc/BRIEF.md
# Double Pile-Up Amplitude Recovery

This block recovers the energy of the second pulse when two detector pulses overlap in one readout window. For a pulse of stable shape the integrated area is a fixed multiple of the amplitude. The area of a two-pulse structure is therefore that multiple times the sum of both amplitudes. The upstream feature extractor supplies four values for each event: the amplitude of the leading pulse, the baseline-subtracted area of the merged structure, the peak-to-peak separation in samples and the first pulse's timestamp. The block then derives the trailing amplitude with one multiply and one subtract. The division by the calibration constant is a multiplication by a programmed fixed-point reciprocal.

Events whose pulses are too close together cannot be recovered, and neither can events holding more than two pulses. Such events are passed on with a rejection code, so that the downstream sorting logic can keep or drop them. The datapath takes one event on every clock and has a fixed latency. Each result carries both amplitudes, both timestamps and a status code.

Top module: `pileup_recover`

## Requirements
- R1: For an accepted event, out_amp2 equals round(in_area * in_recip / 65536) minus in_amp1, with in_recip read as an unsigned Q0.16 fraction, and out_status is 0.
- R2: The division by 65536 rounds half up: a remainder of 32768 or more increments the quotient, and a remainder of 32767 or less truncates it.
- R3: When the difference of R1 is negative, out_amp2 is 0 and out_status is 3.
- R4: When the difference of R1 exceeds 65535, out_amp2 is 65535 and out_status is 4.
- R5: When in_sep is below the limit, the event is rejected: out_status is 1 and out_amp2 is 0. A separation equal to the limit is accepted. A non-zero in_min_sep is the limit.
- R6: When in_min_sep is 0, the limit is 7 samples.
- R7: When in_multi is 1, the event is rejected with out_status 2 and out_amp2 0. This code wins over the code of R5.
- R8: out_amp1 equals in_amp1, out_t1 equals in_t1, and out_t2 equals in_t1 + in_sep modulo 2^24.
- R9: An event sampled with in_valid at rising edge n appears with out_valid high right after edge n+2, and it stays for one cycle. A new event can be accepted on every clock.
- R10: After a synchronous reset, out_valid and all output data fields are 0.
- R11: While out_valid is low, all output data fields keep their last values. Inputs sampled while in_valid is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Event present on the inputs |
| in_amp1 | input | 16 | Amplitude of the leading pulse |
| in_area | input | 22 | Baseline-subtracted area of the merged pulses |
| in_recip | input | 16 | Reciprocal of the area-to-amplitude constant, Q0.16 |
| in_t1 | input | 24 | Timestamp of the leading pulse |
| in_sep | input | 8 | Peak-to-peak separation in samples |
| in_min_sep | input | 8 | Minimum accepted separation; 0 selects 7 |
| in_multi | input | 1 | More than two pulses were detected |
| out_valid | output | 1 | Result present |
| out_amp1 | output | 16 | Leading amplitude |
| out_amp2 | output | 16 | Recovered trailing amplitude |
| out_t1 | output | 24 | Leading timestamp |
| out_t2 | output | 24 | Trailing timestamp |
| out_status | output | 3 | 0 ok, 1 too close, 2 multi-pulse, 3 clamped negative, 4 saturated |

## Verification
The bound checker checks the following on every cycle: the three-stage timing of out_valid against in_valid, that the timestamps and the leading amplitude pass through unchanged, the rejection codes for close and multi-pulse events, the zero and full-scale values that go with the clamp codes, and that the output fields hold while no result is present. The arithmetic itself can only be shown by the bench. This covers the rounding boundary at a remainder of exactly half, which status is chosen for a given area and reciprocal, the acceptance of a separation exactly at the limit, and timestamp wrap-around. The bench computes all of these from the requirements under random and directed events.

// File: rtl/pileup_pkg.sv
package pileup_pkg;

  typedef enum logic [2:0] {
    PR_OK    = 3'd0,
    PR_CLOSE = 3'd1,
    PR_MULTI = 3'd2,
    PR_NEG   = 3'd3,
    PR_SAT   = 3'd4
  } pr_status_e;

  function automatic logic is_reject(input logic [2:0] st);
    return (st == PR_CLOSE) || (st == PR_MULTI);
  endfunction

endpackage

// File: rtl/pr_classify.sv
module pr_classify #(
  parameter int AW      = 16,
  parameter int IW      = 22,
  parameter int RW      = 16,
  parameter int TW      = 24,
  parameter int SW      = 8,
  parameter int DEF_SEP = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_i,
  input  logic [AW-1:0] amp1_i,
  input  logic [IW-1:0] area_i,
  input  logic [RW-1:0] recip_i,
  input  logic [TW-1:0] t1_i,
  input  logic [SW-1:0] sep_i,
  input  logic [SW-1:0] min_sep_i,
  input  logic          multi_i,
  output logic          v_o,
  output logic [AW-1:0] amp1_o,
  output logic [IW-1:0] area_o,
  output logic [RW-1:0] recip_o,
  output logic [TW-1:0] t1_o,
  output logic [TW-1:0] t2_o,
  output logic [2:0]    st_o,
  output logic          close_o,
  output logic          multi_o
);
  import pileup_pkg::*;

  localparam logic [SW-1:0] DEF_LIM = SW'(DEF_SEP);

  // zero in the programmed limit falls back to the built-in default
  function automatic logic [SW-1:0] pick_limit(input logic [SW-1:0] prog);
    return (prog == '0) ? DEF_LIM : prog;
  endfunction

  function automatic logic [TW-1:0] stamp_second(input logic [TW-1:0] t1,
                                                 input logic [SW-1:0] sep);
    return t1 + TW'(sep);
  endfunction

  // multi-pulse wins over the separation check
  function automatic logic [2:0] decide(input logic multi, input logic close);
    if (multi)      return PR_MULTI;
    else if (close) return PR_CLOSE;
    else            return PR_OK;
  endfunction

  logic [SW-1:0] limit;

  assign limit   = pick_limit(min_sep_i);
  assign close_o = v_i & (sep_i < limit);
  assign multi_o = v_i & multi_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o     <= 1'b0;
      amp1_o  <= '0;
      area_o  <= '0;
      recip_o <= '0;
      t1_o    <= '0;
      t2_o    <= '0;
      st_o    <= PR_OK;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        amp1_o  <= amp1_i;
        area_o  <= area_i;
        recip_o <= recip_i;
        t1_o    <= t1_i;
        t2_o    <= stamp_second(t1_i, sep_i);
        st_o    <= decide(multi_o, close_o);
      end
    end
  end

endmodule

// File: rtl/pr_scale.sv
module pr_scale #(
  parameter int AW = 16,
  parameter int IW = 22,
  parameter int RW = 16,
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_i,
  input  logic [AW-1:0] amp1_i,
  input  logic [IW-1:0] area_i,
  input  logic [RW-1:0] recip_i,
  input  logic [TW-1:0] t1_i,
  input  logic [TW-1:0] t2_i,
  input  logic [2:0]    st_i,
  output logic          v_o,
  output logic [AW-1:0] amp1_o,
  output logic [IW:0]   scaled_o,
  output logic [TW-1:0] t1_o,
  output logic [TW-1:0] t2_o,
  output logic [2:0]    st_o
);

  localparam int              PW   = IW + RW + 1;
  localparam logic [PW-1:0]   HALF = PW'(1) << (RW - 1);

  // area times reciprocal, shifted down by the fraction width, half rounds up
  function automatic logic [IW:0] round_scale(input logic [IW-1:0] a,
                                               input logic [RW-1:0] r);
    logic [PW-1:0] p;
    p = PW'(a) * PW'(r) + HALF;
    return p[PW-1:RW];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o      <= 1'b0;
      amp1_o   <= '0;
      scaled_o <= '0;
      t1_o     <= '0;
      t2_o     <= '0;
      st_o     <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        amp1_o   <= amp1_i;
        scaled_o <= round_scale(area_i, recip_i);
        t1_o     <= t1_i;
        t2_o     <= t2_i;
        st_o     <= st_i;
      end
    end
  end

endmodule

// File: rtl/pr_resolve.sv
module pr_resolve #(
  parameter int AW = 16,
  parameter int IW = 22,
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_i,
  input  logic [AW-1:0] amp1_i,
  input  logic [IW:0]   scaled_i,
  input  logic [TW-1:0] t1_i,
  input  logic [TW-1:0] t2_i,
  input  logic [2:0]    st_i,
  output logic          v_o,
  output logic [AW-1:0] amp1_o,
  output logic [AW-1:0] amp2_o,
  output logic [TW-1:0] t1_o,
  output logic [TW-1:0] t2_o,
  output logic [2:0]    st_o,
  output logic          neg_hit,
  output logic          sat_hit
);
  import pileup_pkg::*;

  localparam int DW  = IW + 2;
  localparam int PAD = DW - AW;
  localparam logic signed [DW-1:0] TOP = $signed({{PAD{1'b0}}, {AW{1'b1}}});

  function automatic logic signed [DW-1:0] remainder_amp(input logic [IW:0] s,
                                                         input logic [AW-1:0] a1);
    return $signed({1'b0, s}) - $signed({{PAD{1'b0}}, a1});
  endfunction

  // returns {status, amplitude}
  function automatic logic [AW+2:0] settle(input logic [2:0] st,
                                           input logic signed [DW-1:0] d);
    if (is_reject(st))  return {st, {AW{1'b0}}};
    else if (d < 0)     return {PR_NEG, {AW{1'b0}}};
    else if (d > TOP)   return {PR_SAT, {AW{1'b1}}};
    else                return {PR_OK, d[AW-1:0]};
  endfunction

  logic signed [DW-1:0] diff;
  logic [AW+2:0]        res;

  assign diff    = remainder_amp(scaled_i, amp1_i);
  assign res     = settle(st_i, diff);
  assign neg_hit = v_i & (res[AW+2:AW] == PR_NEG);
  assign sat_hit = v_i & (res[AW+2:AW] == PR_SAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o    <= 1'b0;
      amp1_o <= '0;
      amp2_o <= '0;
      t1_o   <= '0;
      t2_o   <= '0;
      st_o   <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        amp1_o <= amp1_i;
        amp2_o <= res[AW-1:0];
        t1_o   <= t1_i;
        t2_o   <= t2_i;
        st_o   <= res[AW+2:AW];
      end
    end
  end

endmodule

// File: rtl/pileup_recover.sv
module pileup_recover #(
  parameter int AW      = 16,
  parameter int IW      = 22,
  parameter int RW      = 16,
  parameter int TW      = 24,
  parameter int SW      = 8,
  parameter int DEF_SEP = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] in_amp1,
  input  logic [IW-1:0] in_area,
  input  logic [RW-1:0] in_recip,
  input  logic [TW-1:0] in_t1,
  input  logic [SW-1:0] in_sep,
  input  logic [SW-1:0] in_min_sep,
  input  logic          in_multi,
  output logic          out_valid,
  output logic [AW-1:0] out_amp1,
  output logic [AW-1:0] out_amp2,
  output logic [TW-1:0] out_t1,
  output logic [TW-1:0] out_t2,
  output logic [2:0]    out_status
);

  // stage 1 -> 2
  logic          c_v;
  logic [AW-1:0] c_amp1;
  logic [IW-1:0] c_area;
  logic [RW-1:0] c_recip;
  logic [TW-1:0] c_t1, c_t2;
  logic [2:0]    c_st;
  // stage 2 -> 3
  logic          s_v;
  logic [AW-1:0] s_amp1;
  logic [IW:0]   s_scaled;
  logic [TW-1:0] s_t1, s_t2;
  logic [2:0]    s_st;
  // named events for the checker
  logic          ev_close, ev_multi, ev_neg, ev_sat;

  pr_classify #(
    .AW(AW), .IW(IW), .RW(RW), .TW(TW), .SW(SW), .DEF_SEP(DEF_SEP)
  ) u_classify (
    .clk(clk), .rst(rst), .v_i(in_valid),
    .amp1_i(in_amp1), .area_i(in_area), .recip_i(in_recip),
    .t1_i(in_t1), .sep_i(in_sep), .min_sep_i(in_min_sep), .multi_i(in_multi),
    .v_o(c_v), .amp1_o(c_amp1), .area_o(c_area), .recip_o(c_recip),
    .t1_o(c_t1), .t2_o(c_t2), .st_o(c_st),
    .close_o(ev_close), .multi_o(ev_multi)
  );

  pr_scale #(
    .AW(AW), .IW(IW), .RW(RW), .TW(TW)
  ) u_scale (
    .clk(clk), .rst(rst), .v_i(c_v),
    .amp1_i(c_amp1), .area_i(c_area), .recip_i(c_recip),
    .t1_i(c_t1), .t2_i(c_t2), .st_i(c_st),
    .v_o(s_v), .amp1_o(s_amp1), .scaled_o(s_scaled),
    .t1_o(s_t1), .t2_o(s_t2), .st_o(s_st)
  );

  pr_resolve #(
    .AW(AW), .IW(IW), .TW(TW)
  ) u_resolve (
    .clk(clk), .rst(rst), .v_i(s_v),
    .amp1_i(s_amp1), .scaled_i(s_scaled),
    .t1_i(s_t1), .t2_i(s_t2), .st_i(s_st),
    .v_o(out_valid), .amp1_o(out_amp1), .amp2_o(out_amp2),
    .t1_o(out_t1), .t2_o(out_t2), .st_o(out_status),
    .neg_hit(ev_neg), .sat_hit(ev_sat)
  );

endmodule

// File: rtl/pileup_recover_chk.sv
module pileup_recover_chk #(
  parameter int AW      = 16,
  parameter int TW      = 24,
  parameter int SW      = 8,
  parameter int DEF_SEP = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [AW-1:0] in_amp1,
  input logic [TW-1:0] in_t1,
  input logic [SW-1:0] in_sep,
  input logic [SW-1:0] in_min_sep,
  input logic          in_multi,
  input logic          out_valid,
  input logic [AW-1:0] out_amp1,
  input logic [AW-1:0] out_amp2,
  input logic [TW-1:0] out_t1,
  input logic [TW-1:0] out_t2,
  input logic [2:0]    out_status,
  input logic          ev_close,
  input logic          ev_multi,
  input logic          ev_neg,
  input logic          ev_sat
);
  import pileup_pkg::*;

  logic [1:0]    cyc;
  logic [TW-1:0] t_sum;

  assign t_sum = in_t1 + TW'(in_sep);

  always_ff @(posedge clk) begin
    if (rst)            cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r8_amp1: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && out_valid) |-> (out_amp1 == $past(in_amp1, 3) && out_t1 == $past(in_t1, 3)));

  a_r8_stamp2: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && out_valid) |-> (out_t2 == $past(t_sum, 3)));

  a_r7_multi: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && $past(ev_multi, 3)) |-> (out_status == PR_MULTI && out_amp2 == '0));

  a_r5_close: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && $past(ev_close && !ev_multi, 3)) |-> (out_status == PR_CLOSE && out_amp2 == '0));

  a_r6_default: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && $past(in_valid && !in_multi && in_min_sep == '0 && in_sep < SW'(DEF_SEP), 3))
      |-> (out_status == PR_CLOSE));

  a_r3_neg_zero: assert property (@(posedge clk) disable iff (rst)
    $past(ev_neg) |-> (out_status == PR_NEG && out_amp2 == '0));

  a_r4_sat_full: assert property (@(posedge clk) disable iff (rst)
    $past(ev_sat) |-> (out_status == PR_SAT && out_amp2 == {AW{1'b1}}));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_amp1) && $stable(out_amp2) && $stable(out_t1)
                    && $stable(out_t2) && $stable(out_status)));

endmodule

bind pileup_recover pileup_recover_chk #(
  .AW(AW), .TW(TW), .SW(SW), .DEF_SEP(DEF_SEP)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_amp1(in_amp1), .in_t1(in_t1),
  .in_sep(in_sep), .in_min_sep(in_min_sep), .in_multi(in_multi),
  .out_valid(out_valid), .out_amp1(out_amp1), .out_amp2(out_amp2),
  .out_t1(out_t1), .out_t2(out_t2), .out_status(out_status),
  .ev_close(ev_close), .ev_multi(ev_multi), .ev_neg(ev_neg), .ev_sat(ev_sat)
);

// File: tb/tb_pileup_recover.sv
module tb_pileup_recover;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] in_amp1;
  logic [21:0] in_area;
  logic [15:0] in_recip;
  logic [23:0] in_t1;
  logic [7:0]  in_sep, in_min_sep;
  logic        in_multi;
  logic        out_valid;
  logic [15:0] out_amp1, out_amp2;
  logic [23:0] out_t1, out_t2;
  logic [2:0]  out_status;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // expected results in flight: index 2 is due at the current check
  bit          hv[3];
  longint      ha1[3], ha2[3], ht1[3], ht2[3], hst[3];
  string       htag[3];
  longint      la1 = 0, la2 = 0, lt1 = 0, lt2 = 0, lst = 0;

  always #5 clk = ~clk;

  pileup_recover dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_amp1(in_amp1), .in_area(in_area),
    .in_recip(in_recip), .in_t1(in_t1), .in_sep(in_sep), .in_min_sep(in_min_sep),
    .in_multi(in_multi), .out_valid(out_valid), .out_amp1(out_amp1), .out_amp2(out_amp2),
    .out_t1(out_t1), .out_t2(out_t2), .out_status(out_status)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // expected record from the requirements
  function automatic void model(input longint a1, input longint area, input longint recip,
                                input longint t1, input longint sep, input longint msep,
                                input bit multi, output longint a2, output longint st,
                                output longint t2);
    longint prod, q, d, lim;
    prod = area * recip;
    q    = prod / 65536;
    if ((prod % 65536) >= 32768) q = q + 1;
    d    = q - a1;
    lim  = (msep == 0) ? 7 : msep;
    t2   = (t1 + sep) % (64'd1 << 24);
    if (multi)          begin st = 2; a2 = 0;     end
    else if (sep < lim) begin st = 1; a2 = 0;     end
    else if (d < 0)     begin st = 3; a2 = 0;     end
    else if (d > 65535) begin st = 4; a2 = 65535; end
    else                begin st = 0; a2 = d;     end
  endfunction

  function automatic string tag_of(input longint st);
    case (st)
      0: return "R1";
      1: return "R5";
      2: return "R7";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic compare_now();
    string t;
    if (hv[2]) begin
      t = (htag[2] == "") ? tag_of(hst[2]) : htag[2];
      chk(out_valid == 1'b1, "R9", "out_valid", out_valid, 1);
      chk(out_amp2 == ha2[2], t, "amp2", out_amp2, ha2[2]);
      chk(out_status == hst[2], t, "status", out_status, hst[2]);
      chk(out_amp1 == ha1[2] && out_t1 == ht1[2], "R8", "amp1/t1", out_t1, ht1[2]);
      chk(out_t2 == ht2[2], "R8", "t2", out_t2, ht2[2]);
      la1 = ha1[2]; la2 = ha2[2]; lt1 = ht1[2]; lt2 = ht2[2]; lst = hst[2];
    end else begin
      chk(out_valid == 1'b0, "R9", "idle out_valid", out_valid, 0);
      chk(out_amp2 == la2 && out_amp1 == la1 && out_status == lst, "R11", "held amp2",
          out_amp2, la2);
      chk(out_t1 == lt1 && out_t2 == lt2, "R11", "held t2", out_t2, lt2);
    end
  endtask

  task automatic step(input bit v, input longint a1, input longint area, input longint recip,
                      input longint t1, input longint sep, input longint msep,
                      input bit multi, input string tag);
    longint a2, st, t2;
    @(negedge clk);
    compare_now();
    for (int i = 2; i > 0; i--) begin
      hv[i] = hv[i-1]; ha1[i] = ha1[i-1]; ha2[i] = ha2[i-1]; ht1[i] = ht1[i-1];
      ht2[i] = ht2[i-1]; hst[i] = hst[i-1]; htag[i] = htag[i-1];
    end
    in_valid   = v;
    in_amp1    = 16'(a1);
    in_area    = 22'(area);
    in_recip   = 16'(recip);
    in_t1      = 24'(t1);
    in_sep     = 8'(sep);
    in_min_sep = 8'(msep);
    in_multi   = multi;
    model(a1, area, recip, t1, sep, msep, multi, a2, st, t2);
    hv[0] = v; ha1[0] = a1; ha2[0] = a2; ht1[0] = t1; ht2[0] = t2; hst[0] = st;
    htag[0] = tag;
  endtask

  // junk on the data inputs with in_valid low must not reach the outputs (R11)
  task automatic idle();
    step(0, longint'($urandom_range(65535)), longint'($urandom_range(4194303)),
         longint'($urandom_range(65535)), longint'($urandom_range(16777215)),
         longint'($urandom_range(255)), 0, 1'($urandom_range(1)), "");
  endtask

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'h5A17);
    for (int i = 0; i < 3; i++) begin hv[i] = 0; htag[i] = ""; end
    rst = 1'b1; in_valid = 0; in_amp1 = 0; in_area = 0; in_recip = 0;
    in_t1 = 0; in_sep = 0; in_min_sep = 0; in_multi = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0 && out_amp1 == 0 && out_t1 == 0, "R10", "reset valid/amp1/t1",
        out_valid, 0);
    chk(out_amp2 == 0 && out_t2 == 0 && out_status == 0, "R10", "reset amp2/t2/status",
        out_amp2, 0);
    rst = 1'b0;

    // directed corners
    step(1, 100, 19200, 1024, 500, 10, 7, 0, "R1");       // 300-100 = 200
    step(1, 0, 1, 32768, 7, 9, 0, 0, "R2");               // remainder exactly half -> 1
    step(1, 0, 1, 32767, 8, 9, 0, 0, "R2");               // just below half -> 0
    step(1, 150, 6400, 1024, 9, 9, 0, 0, "R3");           // 100-150 < 0
    step(1, 5, 4194303, 65535, 10, 9, 0, 0, "R4");        // far above full scale
    step(1, 10, 19200, 1024, 11, 9, 10, 0, "R5");         // one below limit
    step(1, 10, 19200, 1024, 12, 10, 10, 0, "R5");        // exactly at limit
    step(1, 10, 19200, 1024, 13, 6, 0, 0, "R6");          // default limit 7, 6 rejected
    step(1, 10, 19200, 1024, 14, 7, 0, 0, "R6");          // default limit 7, 7 accepted
    step(1, 10, 19200, 1024, 15, 0, 0, 1, "R7");          // multi beats close
    step(1, 10, 19200, 1024, 16, 20, 0, 1, "R7");
    step(1, 1, 640, 1024, 24'hFFFFF0, 8'h20, 0, 0, "R8"); // t2 wraps
    repeat (3) idle();

    // constrained random with a plausible calibration constant
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(3) == 0) idle();
      else begin
        longint k, a1, a2, area, mp;
        int sel;
        k    = longint'($urandom_range(60, 4));
        a1   = longint'($urandom_range(30000));
        a2   = longint'($urandom_range(30000));
        area = k * (a1 + a2) + longint'($urandom_range(40)) - 20;
        if (area < 0) area = 0;
        if ($urandom_range(9) == 0) area = longint'($urandom_range(4194303));
        sel  = int'($urandom_range(3));
        mp   = (sel == 0) ? 0 : (sel == 1) ? 5 : (sel == 2) ? 7 : 10;
        step(1, a1, area, 65535 / k, longint'($urandom_range(16777215)),
             longint'($urandom_range(20)), mp, ($urandom_range(15) == 0), "");
      end
    end
    repeat (4) idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule